// File: doc/BRIEF.md
# Multi-format pixel unpacker

This block sits between a frame-buffer fetch stream and a panel interface. It takes 32-bit memory words on a ready/valid input and produces 24-bit RGB pixels, one per accepted output handshake, on a ready/valid output. Four packed formats are understood: a 24-bit format with one pixel per word, and three 16-bit formats (5:6:5, 1:5:5:5 and 4:4:4) that pack two pixels per word. Narrow channels are widened to 8 bits by repeating their upper bits into the vacated low bits, so full-scale values map to full scale.

Channels are read with red in the least significant field of each pixel. A single swap control exchanges the red and blue roles for every format, while green keeps its position. The format and swap controls are captured only when a frame-start strobe is high, so software may change them at any time without disturbing a frame in flight. A held word is released only when its last pixel leaves, and a stalled output keeps its pixel steady.

Top module: `pix_unpack`

## Requirements
- R1: Format code 2'b00 (24-bit): red = word[7:0], green = word[15:8], blue = word[23:16]; word[31:24] has no effect; each word gives exactly one pixel.
- R2: Format code 2'b01 (5:6:5): within a 16-bit pixel, red = bits [4:0], green = bits [10:5], blue = bits [15:11].
- R3: Format code 2'b10 (1:5:5:5): red = bits [4:0], green = bits [9:5], blue = bits [14:10]; bit 15 has no effect.
- R4: Format code 2'b11 (4:4:4): red = bits [3:0], green = bits [7:4], blue = bits [11:8]; bits [15:12] have no effect.
- R5: A 5-bit channel c widens to {c, c[4:2]}, a 6-bit channel to {c, c[5:4]}, a 4-bit channel to {c, c}.
- R6: With the swap control set, the fields read as red and blue in R1 to R4 are exchanged; green is unchanged.
- R7: The output carries red on out_pix[7:0], green on out_pix[15:8] and blue on out_pix[23:16].
- R8: In the 16-bit formats, the pixel from word[15:0] is output before the pixel from word[31:16].
- R9: in_ready is high only when no word is held, or when the last pixel of the held word is taken in the same cycle; a word offered earlier waits.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_pix does not change.
- R11: Format and swap controls take effect only from the clock edge at which frame_start is high; after reset the block uses 24-bit format with no swap.
- R12: During and directly after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe that captures fmt_sel and bgr_swap |
| fmt_sel | input | 2 | Pixel format code (see R1 to R4) |
| bgr_swap | input | 1 | Exchange red and blue channel sources |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | WORD_W | Frame-buffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pix | output | 24 | Pixel: blue, green, red from high to low byte |

## Verification
The bench builds the block with the default WORD_W of 32, which gives two 16-bit lanes per word and so brings both the single-pixel and the two-pixel word sequencing within reach, along with the lane order. Every format is exercised with and without the swap control, using words whose ignored bits are set so that a leak into the output shows. Stall windows with a second word waiting probe the hold-off of in_ready and the same-cycle refill when the last pixel leaves, and a format change made without the strobe probes the capture rule.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  localparam int CH_W   = 8;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    FMT_RGB24 = 2'b00,
    FMT_565   = 2'b01,
    FMT_1555  = 2'b10,
    FMT_444   = 2'b11
  } pix_fmt_e;

  typedef struct packed {
    pix_fmt_e fmt;
    logic     swap;
  } pix_cfg_t;

  // packed so that red lands in the low byte of the flattened vector
  typedef struct packed {
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } rgb_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] widen4(input logic [3:0] c);
    return {c, c};
  endfunction

  // one 16-bit pixel; lo_ch is the least significant colour field
  function automatic rgb_t decode_half(input pix_fmt_e fmt, input logic [HALF_W-1:0] h);
    logic [CH_W-1:0] lo_ch, mid_ch, hi_ch;
    rgb_t res;
    case (fmt)
      FMT_565: begin
        lo_ch  = widen5(h[4:0]);
        mid_ch = widen6(h[10:5]);
        hi_ch  = widen5(h[15:11]);
      end
      FMT_1555: begin
        lo_ch  = widen5(h[4:0]);
        mid_ch = widen5(h[9:5]);
        hi_ch  = widen5(h[14:10]);
      end
      default: begin
        lo_ch  = widen4(h[3:0]);
        mid_ch = widen4(h[7:4]);
        hi_ch  = widen4(h[11:8]);
      end
    endcase
    res.r = lo_ch;
    res.g = mid_ch;
    res.b = hi_ch;
    return res;
  endfunction

  function automatic rgb_t decode_true(input logic [23:0] w);
    rgb_t res;
    res.r = w[7:0];
    res.g = w[15:8];
    res.b = w[23:16];
    return res;
  endfunction

  function automatic rgb_t apply_swap(input rgb_t p, input logic swap);
    rgb_t res;
    res = p;
    if (swap) begin
      res.r = p.b;
      res.b = p.r;
    end
    return res;
  endfunction

endpackage

// File: rtl/pix_cfg_reg.sv
module pix_cfg_reg
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] fmt_sel,
  input  logic       bgr_swap,
  output pix_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.fmt  <= FMT_RGB24;
      cfg.swap <= 1'b0;
    end else if (frame_start) begin
      cfg.fmt  <= pix_fmt_e'(fmt_sel);
      cfg.swap <= bgr_swap;
    end
  end

endmodule

// File: rtl/pix_word_hold.sv
module pix_word_hold #(
  parameter int WORD_W = 32,
  parameter int LANES  = 2,
  localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_pix,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              full,
  output logic [WORD_W-1:0] word_q,
  output logic [SLOT_W-1:0] slot,
  output logic              last_slot,
  output logic              pix_fire,
  output logic              word_fire
);

  assign last_slot = one_pix || (slot == SLOT_W'(LANES - 1));
  assign pix_fire  = full && out_ready;
  assign in_ready  = !full || (pix_fire && last_slot);
  assign word_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      slot   <= '0;
      word_q <= '0;
    end else if (word_fire) begin
      full   <= 1'b1;
      slot   <= '0;
      word_q <= in_word;
    end else if (pix_fire) begin
      if (last_slot) begin
        full <= 1'b0;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pix_lane_decode.sv
module pix_lane_decode
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE   = 0
) (
  input  pix_cfg_t          cfg,
  input  logic [WORD_W-1:0] word,
  output rgb_t              pix
);

  logic [HALF_W-1:0] half;
  rgb_t              raw;

  assign half = word[LANE*HALF_W +: HALF_W];

  always_comb begin
    if (cfg.fmt == FMT_RGB24) begin
      raw = decode_true(word[23:0]);
    end else begin
      raw = decode_half(cfg.fmt, half);
    end
    pix = apply_swap(raw, cfg.swap);
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / HALF_W,
  localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        fmt_sel,
  input  logic              bgr_swap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [23:0]       out_pix
);

  pix_cfg_t          cfg;
  logic              full;
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot;
  logic              last_slot;
  logic              pix_fire;
  logic              word_fire;
  logic              one_pix;
  rgb_t              lane_pix [LANES];

  pix_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fmt_sel     (fmt_sel),
    .bgr_swap    (bgr_swap),
    .cfg         (cfg)
  );

  assign one_pix = (cfg.fmt == FMT_RGB24);

  pix_word_hold #(.WORD_W(WORD_W), .LANES(LANES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .one_pix   (one_pix),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .full      (full),
    .word_q    (word_q),
    .slot      (slot),
    .last_slot (last_slot),
    .pix_fire  (pix_fire),
    .word_fire (word_fire)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    pix_lane_decode #(.WORD_W(WORD_W), .LANE(ln)) u_dec (
      .cfg  (cfg),
      .word (word_q),
      .pix  (lane_pix[ln])
    );
  end

  assign out_valid = full;
  assign out_pix   = lane_pix[slot];

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
  parameter int SLOT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [23:0]       out_pix,
  input logic              in_ready,
  input logic              word_fire,
  input logic              pix_fire,
  input logic              last_slot,
  input logic [SLOT_W-1:0] slot,
  input logic [1:0]        cfg_fmt
);

  // R10: a stalled pixel stays put
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=> (out_valid && $stable(out_pix)));

  // R9: an accepted word is presented next cycle
  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire |=> out_valid);

  // R9: no acceptance while pixels of the held word remain
  a_r9_no_accept_midword: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !last_slot) |-> !in_ready);

  // R8: taking a non-final pixel moves to the next lane
  a_r8_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && !last_slot && !word_fire) |=> (out_valid && (slot != $past(slot))));

  // R5: 4-bit channels repeat their nibble
  a_r5_nibble_rep: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_fmt == 2'b11) |->
      (out_pix[3:0] == out_pix[7:4] && out_pix[11:8] == out_pix[15:12] &&
       out_pix[19:16] == out_pix[23:20]));

  // R5: 6-bit green repeats its top two bits
  a_r5_green6_rep: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_fmt == 2'b01) |-> (out_pix[9:8] == out_pix[15:14]));

  // R11: configuration moves only on the strobe
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_fmt));

endmodule

bind pix_unpack pix_unpack_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_pix     (out_pix),
  .in_ready    (in_ready),
  .word_fire   (word_fire),
  .pix_fire    (pix_fire),
  .last_slot   (last_slot),
  .slot        (slot),
  .cfg_fmt     (cfg.fmt)
);

// File: tb/pix_unpack_test.sv
module pix_unpack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bgr_swap = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pix;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pix_unpack uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fmt_sel     (fmt_sel),
    .bgr_swap    (bgr_swap),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_word     (in_word),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_pix     (out_pix)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // scale an n-bit value to 8 bits by repeating it from the top down
  function automatic logic [7:0] stretch(input int v, input int n);
    logic [15:0] acc;
    acc = 16'(v) << (16 - n);
    acc = acc | (acc >> n) | (acc >> (2 * n));
    return acc[15:8];
  endfunction

  function automatic logic [23:0] model(input int fmt, input bit sw, input logic [31:0] w, input int idx);
    int h, rv, gv, bv;
    logic [7:0] r, g, b, t;
    h = (idx == 0) ? int'(w & 32'hffff) : int'(w >> 16);
    case (fmt)
      0: begin
        r = w[7:0]; g = w[15:8]; b = w[23:16];
      end
      1: begin
        rv = h % 32; gv = (h / 32) % 64; bv = (h / 2048) % 32;
        r = stretch(rv, 5); g = stretch(gv, 6); b = stretch(bv, 5);
      end
      2: begin
        rv = h % 32; gv = (h / 32) % 32; bv = (h / 1024) % 32;
        r = stretch(rv, 5); g = stretch(gv, 5); b = stretch(bv, 5);
      end
      default: begin
        rv = h % 16; gv = (h / 16) % 16; bv = (h / 256) % 16;
        r = 8'(rv * 17); g = 8'(gv * 17); b = 8'(bv * 17);
      end
    endcase
    if (sw) begin t = r; r = b; b = t; end
    return {b, g, r};
  endfunction

  task automatic set_cfg(input logic [1:0] f, input bit sw);
    @(negedge clk);
    fmt_sel = f; bgr_swap = sw; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // push one word into an empty block and read its pixels
  task automatic push_check(input string tag, input int fmt, input bit sw,
                            input logic [31:0] w, input int npix);
    @(negedge clk);
    check({tag, " ready while empty (R12)"}, in_ready, 1);
    in_word = w; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < npix; i++) begin
      check({tag, " valid"}, out_valid, 1);
      check({tag, " pixel"}, out_pix, model(fmt, sw, w, i));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    check({tag, " drained (R1/R8 pixel count)"}, out_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12 out_valid in reset", out_valid, 0);
    check("R12 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_default_cfg();
    // R11: default is 24-bit, no swap
    push_check("R11 default cfg", 0, 0, 32'hFF12_3456, 1);
  endtask

  task automatic t_rgb24();
    set_cfg(2'b00, 1'b0);
    push_check("R1 24-bit", 0, 0, 32'hA5C3_8E17, 1);
    push_check("R1 top byte ignored", 0, 0, 32'h00C3_8E17, 1);
    set_cfg(2'b00, 1'b1);
    push_check("R6 24-bit swap", 0, 1, 32'h5A11_2233, 1);
  endtask

  task automatic t_565();
    set_cfg(2'b01, 1'b0);
    // hand value: low pixel 0xF800 is full blue, high pixel 0x001F full red (R7)
    @(negedge clk);
    in_word = 32'h001F_F800; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2/R7 565 blue byte", out_pix, 24'hFF0000);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    check("R8/R7 565 second red byte", out_pix, 24'h0000FF);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    push_check("R2/R5 565", 1, 0, 32'h7BEF_A5A5, 2);
    push_check("R2/R8 565 order", 1, 0, 32'h07E0_0010, 2);
    set_cfg(2'b01, 1'b1);
    push_check("R6 565 swap", 1, 1, 32'hF81F_07E3, 2);
  endtask

  task automatic t_1555();
    set_cfg(2'b10, 1'b0);
    push_check("R3 1555 top bit set", 1 + 1, 0, 32'hFFFF_8421, 2);
    push_check("R3 1555 top bit clear", 2, 0, 32'h7FFF_0421, 2);
    set_cfg(2'b10, 1'b1);
    push_check("R6 1555 swap", 2, 1, 32'h7C00_801F, 2);
  endtask

  task automatic t_444();
    set_cfg(2'b11, 1'b0);
    push_check("R4 444 nibble ignored", 3, 0, 32'hF123_A9BC, 2);
    push_check("R4/R5 444", 3, 0, 32'h0F0F_00F0, 2);
    set_cfg(2'b11, 1'b1);
    push_check("R6 444 swap", 3, 1, 32'h0ABC_5123, 2);
  endtask

  task automatic t_backpressure();
    logic [31:0] wa, wb;
    logic [23:0] held;
    wa = 32'h1234_ABCD; wb = 32'h8765_4321;
    set_cfg(2'b01, 1'b0);
    @(negedge clk);
    in_word = wa; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_word = wb;
    held = out_pix;
    check("R10 first pixel", out_pix, model(1, 0, wa, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 second word waits", in_ready, 0);
      check("R10 valid held", out_valid, 1);
      check("R10 pixel stable", out_pix, held);
    end
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    #1;
    check("R9 still waiting on last pixel", in_ready, 0);
    check("R8 upper pixel", out_pix, model(1, 0, wa, 1));
    out_ready = 1'b1;
    #1;
    check("R9 same-cycle refill", in_ready, 1);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    check("R9 refilled word low", out_pix, model(1, 0, wb, 0));
    out_ready = 1'b1; @(negedge clk);
    check("R9 refilled word high", out_pix, model(1, 0, wb, 1));
    @(negedge clk); out_ready = 1'b0;
    check("R9 drained", out_valid, 0);
  endtask

  task automatic t_strobe_gate();
    set_cfg(2'b00, 1'b0);
    @(negedge clk);
    fmt_sel = 2'b11; bgr_swap = 1'b1;
    push_check("R11 change without strobe", 0, 0, 32'h00AB_CDEF, 1);
    set_cfg(2'b11, 1'b1);
    push_check("R11 change with strobe", 3, 1, 32'h00AB_CDEF, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_default_cfg();
    t_rgb24();
    t_565();
    t_1555();
    t_444();
    t_backpressure();
    t_strobe_gate();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule